// File: doc/BRIEF.md
# Disk Controller Command Register File

This block holds the programmer-visible registers of a 12-bit disk controller and decodes the processor's I/O transfer commands that target them. A command arrives as a 12-bit code, written here as four octal digits, together with a 12-bit accumulator value. The code is qualified by a valid strobe. A load code writes one register from the accumulator. A read code places one register on a 12-bit read bus in the same cycle, and the register file is left as it was.

The registers are two command registers (A and B), a 6-bit sector address, a break memory address and a word count. Their decoded fields go to the transfer engine: the seek direction, the head select, the cylinder value, the drive select, the memory field, the interrupt enable and the byte/word mode. A 16-bit disk address is also formed from command register A and the sector address. Writing command register B stores its fields and starts the encoded function. On that write the block gives a one-cycle execute pulse carrying the function code, and a matching pulse that clears the low three error bits held elsewhere.

Top module: `dskc_regfile`

## Requirements
- R1: Code 6603 (octal) loads command register A from the accumulator at the clock edge. Code 6612 returns command register A on the read bus.
- R2: Code 6604 loads command register B from the accumulator at the clock edge. Code 6613 returns command register B on the read bus.
- R3: The command register B fields are decoded with bit 0 as the LSB: function code in bits 2:0, memory field in bits 5:3, drive select in bits 7:6, interrupt enable in bit 8, and byte mode in bit 9 (1 = 8-bit bytes, 0 = 12-bit words).
- R4: Each load of command register B raises the execute pulse for exactly one cycle, in the cycle in which the new register value appears. The function code output then equals accumulator bits 2:0. Codes 0 to 7 stand for maintenance, reset, get status, seek, read header, write data, read data, and read data without header check.
- R5: The error-clear pulse is high in exactly the cycles in which the execute pulse is high.
- R6: Code 6605 loads the 6-bit sector address from accumulator bits 5:0. Code 6614 returns it zero-extended to 12 bits.
- R7: Code 6607 loads the word count and code 6611 returns it. Code 6602 loads the break memory address, which is visible on its own output port.
- R8: A read code changes no register. When no read code is presented, the read bus is 0 and the read-hit flag is 0.
- R9: Bus initialize clears every register and the pulse outputs at the next edge, and it takes priority over a load presented in the same cycle.
- R10: Command register A is decoded as direction in bit 11 (1 = toward higher cylinders), head select in bit 10 (1 = lower head) and cylinder value in bits 8:0. The disk address is {head, cylinder[8:0], sector[5:0]}.
- R11: Any other code, or any code presented while the valid strobe is low, changes no register and produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_init | input | 1 | Synchronous bus initialize, clears all registers |
| iot_valid | input | 1 | Command strobe |
| iot_code | input | 12 | Command code (octal 66xx) |
| acc_in | input | 12 | Accumulator value for loads |
| rd_data | output | 12 | Read bus, valid in the cycle of a read code |
| rd_hit | output | 1 | A read code was decoded this cycle |
| cmd_a | output | 12 | Command register A |
| cmd_b | output | 12 | Command register B |
| seek_dir | output | 1 | Seek direction, 1 = higher cylinders |
| head_sel | output | 1 | Head select, 1 = lower head |
| cyl_val | output | 9 | Cylinder address or cylinder difference |
| byte_mode | output | 1 | 1 = 8-bit byte mode |
| int_en | output | 1 | Interrupt enable |
| drive_sel | output | 2 | Drive select |
| mem_field | output | 3 | Extended memory field |
| sector | output | 6 | Sector address |
| disk_addr | output | 16 | Head, cylinder and sector combined |
| brk_addr | output | 12 | Break memory address |
| word_cnt | output | 12 | Word count |
| exec_pulse | output | 1 | One-cycle execute pulse |
| exec_func | output | 3 | Function code |
| err_clr | output | 1 | One-cycle clear of the low error bits |

## Verification
Random commands are drawn so that load, read, unassigned and strobe-low cycles are mixed, with random accumulator values. This exposes a wrong decode, since a register then changes on a code that is not its own. Back-to-back command register B loads test whether the execute pulse is held or repeated. A read that follows each load tells read routing apart from load routing. Directed cases cover an initialize in the same cycle as a load, and all-ones values, which show that the sector address drops the upper accumulator bits.

// File: rtl/dskc_regfile.sv
module dskc_regfile #(
  parameter int W  = 12,
  parameter int SW = 6,
  parameter int CW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_init,
  input  logic          iot_valid,
  input  logic [W-1:0]  iot_code,
  input  logic [W-1:0]  acc_in,
  output logic [W-1:0]  rd_data,
  output logic          rd_hit,
  output logic [W-1:0]  cmd_a,
  output logic [W-1:0]  cmd_b,
  output logic          seek_dir,
  output logic          head_sel,
  output logic [CW-1:0] cyl_val,
  output logic          byte_mode,
  output logic          int_en,
  output logic [1:0]    drive_sel,
  output logic [2:0]    mem_field,
  output logic [SW-1:0] sector,
  output logic [CW+SW:0] disk_addr,
  output logic [W-1:0]  brk_addr,
  output logic [W-1:0]  word_cnt,
  output logic          exec_pulse,
  output logic [2:0]    exec_func,
  output logic          err_clr
);

  localparam logic [W-1:0] C_LD_BMA = 12'o6602;
  localparam logic [W-1:0] C_LD_CRA = 12'o6603;
  localparam logic [W-1:0] C_LD_CRB = 12'o6604;
  localparam logic [W-1:0] C_LD_SA  = 12'o6605;
  localparam logic [W-1:0] C_LD_WC  = 12'o6607;
  localparam logic [W-1:0] C_RD_WC  = 12'o6611;
  localparam logic [W-1:0] C_RD_CRA = 12'o6612;
  localparam logic [W-1:0] C_RD_CRB = 12'o6613;
  localparam logic [W-1:0] C_RD_SA  = 12'o6614;

  logic [W-1:0]  cra_q, crb_q, bma_q, wc_q;
  logic [SW-1:0] sa_q;
  logic          exec_q;

  wire ld_ok  = iot_valid && !bus_init;
  wire ld_bma = ld_ok && iot_code == C_LD_BMA;
  wire ld_cra = ld_ok && iot_code == C_LD_CRA;
  wire ld_crb = ld_ok && iot_code == C_LD_CRB;
  wire ld_sa  = ld_ok && iot_code == C_LD_SA;
  wire ld_wc  = ld_ok && iot_code == C_LD_WC;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cra_q  <= '0;
      crb_q  <= '0;
      bma_q  <= '0;
      wc_q   <= '0;
      sa_q   <= '0;
      exec_q <= 1'b0;
    end else if (bus_init) begin
      cra_q  <= '0;
      crb_q  <= '0;
      bma_q  <= '0;
      wc_q   <= '0;
      sa_q   <= '0;
      exec_q <= 1'b0;
    end else begin
      if (ld_cra) cra_q <= acc_in;
      if (ld_crb) crb_q <= acc_in;
      if (ld_bma) bma_q <= acc_in;
      if (ld_wc)  wc_q  <= acc_in;
      if (ld_sa)  sa_q  <= acc_in[SW-1:0];
      exec_q <= ld_crb;
    end
  end

  always_comb begin
    rd_data = '0;
    rd_hit  = 1'b0;
    if (iot_valid) begin
      unique case (iot_code)
        C_RD_CRA: begin rd_data = cra_q; rd_hit = 1'b1; end
        C_RD_CRB: begin rd_data = crb_q; rd_hit = 1'b1; end
        C_RD_WC:  begin rd_data = wc_q;  rd_hit = 1'b1; end
        C_RD_SA:  begin rd_data = {{(W-SW){1'b0}}, sa_q}; rd_hit = 1'b1; end
        default:  ;
      endcase
    end
  end

  assign cmd_a      = cra_q;
  assign cmd_b      = crb_q;
  assign seek_dir   = cra_q[W-1];
  assign head_sel   = cra_q[W-2];
  assign cyl_val    = cra_q[CW-1:0];
  assign sector     = sa_q;
  assign disk_addr  = {head_sel, cyl_val, sa_q};
  assign exec_func  = crb_q[2:0];
  assign mem_field  = crb_q[5:3];
  assign drive_sel  = crb_q[7:6];
  assign int_en     = crb_q[8];
  assign byte_mode  = crb_q[9];
  assign brk_addr   = bma_q;
  assign word_cnt   = wc_q;
  assign exec_pulse = exec_q;
  assign err_clr    = exec_q;

  p_load_cra_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (iot_valid && !bus_init && iot_code == C_LD_CRA) |=> cmd_a == $past(acc_in));

  p_exec_func_r4: assert property (@(posedge clk) disable iff (!rst_n)
    exec_pulse |-> exec_func == $past(acc_in[2:0]) && $past(iot_valid));

  p_exec_needs_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!iot_valid || iot_code != C_LD_CRB || bus_init) |=> !exec_pulse);

  p_err_with_exec_r5: assert property (@(posedge clk) disable iff (!rst_n)
    err_clr == exec_pulse);

  p_read_no_change_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && !bus_init) |=> $stable(cmd_a) && $stable(cmd_b) && $stable(sector)
      && $stable(word_cnt) && $stable(brk_addr));

  p_init_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_init |=> cmd_a == '0 && cmd_b == '0 && sector == '0 && word_cnt == '0
      && brk_addr == '0 && !exec_pulse);

  p_idle_bus_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !iot_valid |-> rd_data == '0 && !rd_hit);

endmodule

// File: tb/dskc_regfile_tb.sv
`timescale 1ns/1ps
module dskc_regfile_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_init = 1'b0;
  logic iot_valid = 1'b0;
  logic [11:0] iot_code = '0;
  logic [11:0] acc_in = '0;
  logic [11:0] rd_data, cmd_a, cmd_b, brk_addr, word_cnt;
  logic rd_hit, seek_dir, head_sel, byte_mode, int_en, exec_pulse, err_clr;
  logic [8:0] cyl_val;
  logic [1:0] drive_sel;
  logic [2:0] mem_field, exec_func;
  logic [5:0] sector;
  logic [15:0] disk_addr;

  always #10 clk = ~clk;

  dskc_regfile dut_i (.*);

  int checks = 0;
  int fails = 0;
  logic [11:0] m_a = 0, m_b = 0, m_bma = 0, m_wc = 0;
  logic [5:0] m_sa = 0;
  logic m_ex = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [12:0] exp_read(logic v, logic [11:0] c);
    if (!v) return 13'h0;
    case (c)
      12'o6612: return {1'b1, m_a};
      12'o6613: return {1'b1, m_b};
      12'o6611: return {1'b1, m_wc};
      12'o6614: return {1'b1, 6'd0, m_sa};
      default:  return 13'h0;
    endcase
  endfunction

  task automatic check_state();
    chk("R1 cmd_a", cmd_a, m_a);
    chk("R2 cmd_b", cmd_b, m_b);
    chk("R3 fields", {byte_mode, int_en, drive_sel, mem_field},
        {m_b[9], m_b[8], m_b[7:6], m_b[5:3]});
    chk("R4 exec", {exec_pulse, exec_func}, {m_ex, m_b[2:0]});
    chk("R5 err_clr", err_clr, m_ex);
    chk("R6 sector", sector, m_sa);
    chk("R7 wc/bma", {word_cnt, brk_addr}, {m_wc, m_bma});
    chk("R10 decode", {seek_dir, head_sel, cyl_val, disk_addr},
        {m_a[11], m_a[10], m_a[8:0], m_a[10], m_a[8:0], m_sa});
  endtask

  task automatic step(logic v, logic [11:0] c, logic [11:0] a, logic ini);
    @(negedge clk);
    check_state();
    iot_valid = v; iot_code = c; acc_in = a; bus_init = ini;
    #1;
    chk("R8 read bus", {rd_hit, rd_data}, exp_read(v, c));
    @(posedge clk);
    m_ex = 1'b0;
    if (ini) begin
      m_a = 0; m_b = 0; m_bma = 0; m_wc = 0; m_sa = 0;
    end else if (v) begin
      case (c)
        12'o6603: m_a = a;
        12'o6604: begin m_b = a; m_ex = 1'b1; end
        12'o6602: m_bma = a;
        12'o6607: m_wc = a;
        12'o6605: m_sa = a[5:0];
        default: ;
      endcase
    end
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [11:0] codes [10];
    void'($urandom(32'd1234));
    codes = '{12'o6602, 12'o6603, 12'o6604, 12'o6605, 12'o6607,
              12'o6611, 12'o6612, 12'o6613, 12'o6614, 12'o6606};
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // reset state (R9)
    step(0, 0, 0, 0);
    // directed: all-ones loads then reads (R1 R2 R6 R7)
    step(1, 12'o6603, 12'o7777, 0);
    step(1, 12'o6612, 12'o0000, 0);
    step(1, 12'o6605, 12'o7777, 0);
    step(1, 12'o6614, 12'o0000, 0);
    step(1, 12'o6607, 12'o1234, 0);
    step(1, 12'o6611, 12'o0000, 0);
    step(1, 12'o6602, 12'o4321, 0);
    // back-to-back B loads (R4 R5)
    step(1, 12'o6604, 12'o1005, 0);
    step(1, 12'o6604, 12'o0263, 0);
    step(1, 12'o6613, 12'o0000, 0);
    // strobe low with load code ignored (R11)
    step(0, 12'o6603, 12'o0000, 0);
    step(1, 12'o6610, 12'o0000, 0);
    // init together with a load (R9)
    step(1, 12'o6604, 12'o0007, 1);
    step(0, 0, 0, 0);
    for (int i = 0; i < 3000; i++) begin
      logic [11:0] c;
      logic [11:0] a;
      logic v;
      c = ($urandom % 8 == 0) ? 12'($urandom) : codes[$urandom % 10];
      a = 12'($urandom);
      v = ($urandom % 6) != 0;
      step(v, c, a, ($urandom % 50) == 0);
    end
    step(0, 0, 0, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule